// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns the two phase signals and the index pulse of an incremental encoder into a signed position count at four counts per line. Every edge on either phase moves the count by one. The order in which the phases change sets the direction: it counts up when phase A leads phase B. The three pins are synchronised, can each be inverted and the two phases can be exchanged. A transition that changes both phases in one sample is flagged as a phase error and does not move the count.

The count resets in one of two ways. In ceiling mode it wraps between 0 and a programmed ceiling. In index mode an index edge clears it, but only when the two phases sit at a selected level combination. Direction changes, wraps, index resets and a step watchdog each raise an event pulse. Each event also sets a sticky status bit, and the unmasked status bits drive an interrupt. A configuration write port loads the controls. The enable bit can always be written, but every other field is taken only while the block is disabled.

Top module: `quad_decoder`

## Requirements
- R1: With phase A leading phase B, each single-phase change increments `count_o` by one (sequence of {A,B}: 00, 10, 11, 01, 00), and `dir_o` reads 1 (up).
- R2: The reverse sequence decrements `count_o` by one per edge and `dir_o` reads 0. A step whose direction differs from `dir_o` pulses `evt_dir_o` and sets status bit 3.
- R3: When `cfg_swap_i` is 1, the A and B pins exchange roles, so a pin sequence that counted up now counts down.
- R4: `cfg_pol_i` bit 0 (A pin), bit 1 (B pin) and bit 2 (index pin) pass their pin unchanged when 1 and invert it when 0. Polarity is applied before the swap.
- R5: A sample in which both phases change sets `perr_o` and leaves `count_o` unchanged. `perr_o` stays set until `perr_clr_i` is pulsed, and a new error in that cycle wins over the clear.
- R6: In ceiling mode (`cfg_mode_i`=1), an up step at the ceiling loads 0 and pulses `evt_rst_up_o` (status bit 2). A down step at 0 loads the ceiling and pulses `evt_rst_dn_o` (status bit 1).
- R7: In index mode (`cfg_mode_i`=0), no ceiling wrap takes place. A rising edge of the conditioned index clears the count only when the conditioned {A,B} levels equal `cfg_gate_i` (0: A low B low, 1: A low B high, 2: A high B low, 3: A high B high). An index edge at any other level combination is ignored.
- R8: A configuration write while enabled updates only the enable bit. Swap, polarity, gate, mode, ceiling and watchdog limit keep their old values.
- R9: While disabled the count, direction and error flag hold. Enabling again resumes counting from the held count, and pin changes made while disabled produce no step.
- R10: With a nonzero watchdog limit L, L enabled cycles without a step pulse `evt_wdt_o` and set status bit 0. A limit of 0 turns the watchdog off.
- R11: Status bits (0 watchdog, 1 down reset, 2 up reset, 3 direction change) are sticky and clear when 1 is written on `sts_clr_i`. `irq_o` is the OR of the status bits whose mask bit is 0, and reset sets every mask bit.
- R12: After reset: `count_o`=0, `dir_o`=1, `perr_o`=0, `sts_o`=0, `irq_o`=0, disabled, polarity 3'b111, ceiling mode, ceiling all ones, watchdog off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Phase A pin |
| b_i | input | 1 | Phase B pin |
| idx_i | input | 1 | Index pin |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable value |
| cfg_swap_i | input | 1 | Exchange phase roles |
| cfg_pol_i | input | 3 | Per-pin polarity {index, B, A} |
| cfg_gate_i | input | 2 | Index gating level code |
| cfg_mode_i | input | 1 | 1 = ceiling wrap, 0 = index reset |
| cfg_ceil_i | input | CNT_W | Ceiling value |
| cfg_wdt_i | input | WDT_W | Watchdog limit in cycles, 0 = off |
| msk_wr_i | input | 1 | Mask write strobe |
| msk_i | input | 4 | Mask value, 1 = masked |
| sts_clr_i | input | 4 | Write-one-to-clear for status |
| perr_clr_i | input | 1 | Clears the phase error flag |
| count_o | output | CNT_W | Position count |
| dir_o | output | 1 | Last step direction, 1 = up |
| perr_o | output | 1 | Sticky phase error |
| evt_wdt_o | output | 1 | Watchdog timeout pulse |
| evt_rst_dn_o | output | 1 | Reset while counting down pulse |
| evt_rst_up_o | output | 1 | Reset while counting up pulse |
| evt_dir_o | output | 1 | Direction change pulse |
| sts_o | output | 4 | Sticky status bits |
| irq_o | output | 1 | Interrupt |

## Verification
The bench builds the block with an 8-bit count and a 4-bit watchdog limit. With these widths a ceiling of 5 and a watchdog limit of 6 take only a handful of steps or cycles to reach. Both wrap directions, index resets past the ceiling and a watchdog timeout are therefore all hit within a short run. The narrow count also makes the up-by-one and down-by-one properties cover the full modular range.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int unsigned EV_W   = 4;
  localparam int unsigned EV_WDT = 0;
  localparam int unsigned EV_DN  = 1;
  localparam int unsigned EV_UP  = 2;
  localparam int unsigned EV_DIR = 3;
  localparam int unsigned NPIN   = 3;

  typedef struct packed {
    logic step;
    logic up;
    logic err;
    logic idx_hit;
  } qdec_smp_t;
endpackage

// File: rtl/qdec_input.sv
module qdec_input
  import qdec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            a_i,
  input  logic            b_i,
  input  logic            idx_i,
  input  logic            swap_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [1:0]      gate_i,
  output qdec_smp_t       smp_o
);
  logic [NPIN-1:0] pin;
  logic [NPIN-1:0] s1_q, s2_q, cond, prev_q, cur;

  assign pin = {idx_i, b_i, a_i};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= pin[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  // pol bit 1 = pass through, 0 = invert
  assign cond = s2_q ^ ~pol_i;
  assign cur  = {cond[2], swap_i ? cond[0] : cond[1], swap_i ? cond[1] : cond[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur;
  end

  logic da, db;
  assign da = cur[0] ^ prev_q[0];
  assign db = cur[1] ^ prev_q[1];

  always_comb begin
    smp_o.step    = da ^ db;
    smp_o.err     = da & db;
    smp_o.up      = cur[0] ^ prev_q[1];
    smp_o.idx_hit = cur[2] & ~prev_q[2] & ({cur[0], cur[1]} == gate_i);
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] ceil_i,
  input  qdec_smp_t        smp_i,
  input  logic             perr_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             perr_o,
  output logic             ev_up_o,
  output logic             ev_dn_o,
  output logic             ev_dir_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic dir_q, dir_d, up_d, dn_d, chg_d, perr_q, perr_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    up_d  = 1'b0;
    dn_d  = 1'b0;
    chg_d = 1'b0;
    if (en_i && smp_i.step) begin
      dir_d = smp_i.up;
      chg_d = smp_i.up != dir_q;
      if (smp_i.up) begin
        if (mode_i && cnt_q == ceil_i) begin
          cnt_d = '0;
          up_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (mode_i && cnt_q == '0) begin
          cnt_d = ceil_i;
          dn_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
    // index reset overrides a step in the same sample
    if (en_i && !mode_i && smp_i.idx_hit) begin
      cnt_d = '0;
      up_d  = dir_d;
      dn_d  = ~dir_d;
    end
    perr_d = (en_i & smp_i.err) | (perr_q & ~perr_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      dir_q    <= 1'b1;
      perr_q   <= 1'b0;
      ev_up_o  <= 1'b0;
      ev_dn_o  <= 1'b0;
      ev_dir_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      dir_q    <= dir_d;
      perr_q   <= perr_d;
      ev_up_o  <= up_d;
      ev_dn_o  <= dn_d;
      ev_dir_o <= chg_d;
    end
  end

  assign count_o = cnt_q;
  assign dir_o   = dir_q;
  assign perr_o  = perr_q;
endmodule

// File: rtl/qdec_watchdog.sv
module qdec_watchdog #(
  parameter int unsigned WDT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WDT_W-1:0] limit_i,
  input  logic             step_i,
  output logic             ev_o
);
  localparam logic [WDT_W-1:0] ONE = {{(WDT_W-1){1'b0}}, 1'b1};
  logic [WDT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ev_o  <= 1'b0;
    end else begin
      ev_o <= 1'b0;
      if (!en_i || limit_i == '0 || step_i) begin
        cnt_q <= '0;
      end else if (cnt_q == limit_i - ONE) begin
        cnt_q <= '0;
        ev_o  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end
endmodule

// File: rtl/qdec_status.sv
module qdec_status
  import qdec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_W-1:0] ev_i,
  input  logic [EV_W-1:0] clr_i,
  input  logic            msk_wr_i,
  input  logic [EV_W-1:0] msk_i,
  output logic [EV_W-1:0] sts_o,
  output logic            irq_o
);
  logic [EV_W-1:0] sts_q, msk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      msk_q <= '1;
    end else begin
      sts_q <= (sts_q & ~clr_i) | ev_i;
      if (msk_wr_i) msk_q <= msk_i;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ~msk_q);
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
  import qdec_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned WDT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             idx_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_en_i,
  input  logic             cfg_swap_i,
  input  logic [2:0]       cfg_pol_i,
  input  logic [1:0]       cfg_gate_i,
  input  logic             cfg_mode_i,
  input  logic [CNT_W-1:0] cfg_ceil_i,
  input  logic [WDT_W-1:0] cfg_wdt_i,
  input  logic             msk_wr_i,
  input  logic [3:0]       msk_i,
  input  logic [3:0]       sts_clr_i,
  input  logic             perr_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             perr_o,
  output logic             evt_wdt_o,
  output logic             evt_rst_dn_o,
  output logic             evt_rst_up_o,
  output logic             evt_dir_o,
  output logic [3:0]       sts_o,
  output logic             irq_o
);
  logic             en_q, swap_q, mode_q;
  logic [2:0]       pol_q;
  logic [1:0]       gate_q;
  logic [CNT_W-1:0] ceil_q;
  logic [WDT_W-1:0] wdt_q;

  // enable always writable, remaining fields only while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      swap_q <= 1'b0;
      pol_q  <= 3'b111;
      gate_q <= 2'd0;
      mode_q <= 1'b1;
      ceil_q <= '1;
      wdt_q  <= '0;
    end else if (cfg_wr_i) begin
      en_q <= cfg_en_i;
      if (!en_q) begin
        swap_q <= cfg_swap_i;
        pol_q  <= cfg_pol_i;
        gate_q <= cfg_gate_i;
        mode_q <= cfg_mode_i;
        ceil_q <= cfg_ceil_i;
        wdt_q  <= cfg_wdt_i;
      end
    end
  end

  qdec_smp_t smp;

  qdec_input u_input (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .idx_i  (idx_i),
    .swap_i (swap_q),
    .pol_i  (pol_q),
    .gate_i (gate_q),
    .smp_o  (smp)
  );

  qdec_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .mode_i     (mode_q),
    .ceil_i     (ceil_q),
    .smp_i      (smp),
    .perr_clr_i (perr_clr_i),
    .count_o    (count_o),
    .dir_o      (dir_o),
    .perr_o     (perr_o),
    .ev_up_o    (evt_rst_up_o),
    .ev_dn_o    (evt_rst_dn_o),
    .ev_dir_o   (evt_dir_o)
  );

  qdec_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_q),
    .limit_i (wdt_q),
    .step_i  (smp.step),
    .ev_o    (evt_wdt_o)
  );

  logic [EV_W-1:0] ev_vec;
  always_comb begin
    ev_vec         = '0;
    ev_vec[EV_WDT] = evt_wdt_o;
    ev_vec[EV_DN]  = evt_rst_dn_o;
    ev_vec[EV_UP]  = evt_rst_up_o;
    ev_vec[EV_DIR] = evt_dir_o;
  end

  qdec_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev_vec),
    .clr_i    (sts_clr_i),
    .msk_wr_i (msk_wr_i),
    .msk_i    (msk_i),
    .sts_o    (sts_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             mode_i,
  input logic [CNT_W-1:0] ceil_i,
  input logic [CNT_W-1:0] count_i,
  input logic             perr_i,
  input logic             perr_clr_i,
  input logic             ev_up_i,
  input logic             ev_dn_i,
  input logic [3:0]       sts_i,
  input logic [3:0]       sts_clr_i
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(count_i));

  a_r6_up_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_up_i |-> count_i == '0);

  a_r6_down_to_ceil: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_dn_i && mode_i) |-> count_i == ceil_i);

  a_r6_one_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_up_i, ev_dn_i}));

  a_r5_perr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_i && !perr_clr_i) |=> perr_i);

  a_r11_sts_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_i & $past(sts_i & ~sts_clr_i)) == $past(sts_i & ~sts_clr_i)));

  a_r1_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_up_i && !ev_dn_i) |-> (count_i == $past(count_i) ||
                                count_i == $past(count_i) + ONE ||
                                count_i == $past(count_i) - ONE));
endmodule

bind quad_decoder qdec_checker #(.CNT_W(CNT_W)) u_qdec_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_q),
  .mode_i     (mode_q),
  .ceil_i     (ceil_q),
  .count_i    (count_o),
  .perr_i     (perr_o),
  .perr_clr_i (perr_clr_i),
  .ev_up_i    (evt_rst_up_o),
  .ev_dn_i    (evt_rst_dn_o),
  .sts_i      (sts_o),
  .sts_clr_i  (sts_clr_i)
);

// File: tb/quad_decoder_bench.sv
module quad_decoder_bench;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned WDT_W = 4;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0, idx = 1'b0;
  logic cfg_wr = 1'b0, cfg_en = 1'b0, cfg_swap = 1'b0, cfg_mode = 1'b1;
  logic [2:0] cfg_pol = 3'b111;
  logic [1:0] cfg_gate = 2'd0;
  logic [CNT_W-1:0] cfg_ceil = '1;
  logic [WDT_W-1:0] cfg_wdt = '0;
  logic msk_wr = 1'b0, perr_clr = 1'b0;
  logic [3:0] msk = 4'hf, sts_clr = 4'h0;

  logic [CNT_W-1:0] count;
  logic dir, perr, ev_wdt, ev_dn, ev_up, ev_dir, irq;
  logic [3:0] sts;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  quad_decoder #(.CNT_W(CNT_W), .WDT_W(WDT_W)) u_quad_decoder (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .idx_i(idx),
    .cfg_wr_i(cfg_wr), .cfg_en_i(cfg_en), .cfg_swap_i(cfg_swap),
    .cfg_pol_i(cfg_pol), .cfg_gate_i(cfg_gate), .cfg_mode_i(cfg_mode),
    .cfg_ceil_i(cfg_ceil), .cfg_wdt_i(cfg_wdt), .msk_wr_i(msk_wr),
    .msk_i(msk), .sts_clr_i(sts_clr), .perr_clr_i(perr_clr),
    .count_o(count), .dir_o(dir), .perr_o(perr), .evt_wdt_o(ev_wdt),
    .evt_rst_dn_o(ev_dn), .evt_rst_up_o(ev_up), .evt_dir_o(ev_dir),
    .sts_o(sts), .irq_o(irq)
  );

  // {a, b, expected count, expected dir}; ceiling 5, ceiling mode
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'd1, 1'b1},
    {1'b1, 1'b1, 8'd2, 1'b1},
    {1'b0, 1'b1, 8'd3, 1'b1},
    {1'b0, 1'b0, 8'd4, 1'b1},
    {1'b1, 1'b0, 8'd5, 1'b1},
    {1'b1, 1'b1, 8'd0, 1'b1},
    {1'b0, 1'b1, 8'd1, 1'b1},
    {1'b1, 1'b1, 8'd0, 1'b0},
    {1'b1, 1'b0, 8'd5, 1'b0},
    {1'b0, 1'b0, 8'd4, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pins(input logic na, input logic nb);
    @(posedge clk); #1;
    a = na; b = nb;
    settle(4);
  endtask

  task automatic cfg(input logic en, input logic sw, input logic [2:0] pol,
                     input logic [1:0] gate, input logic mode,
                     input logic [CNT_W-1:0] ceil, input logic [WDT_W-1:0] wdt);
    @(posedge clk); #1;
    cfg_en = en; cfg_swap = sw; cfg_pol = pol; cfg_gate = gate;
    cfg_mode = mode; cfg_ceil = ceil; cfg_wdt = wdt; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    settle(3);
  endtask

  task automatic clear_sts(input logic [3:0] m);
    @(posedge clk); #1;
    sts_clr = m;
    @(posedge clk); #1;
    sts_clr = 4'h0;
    settle(1);
  endtask

  task automatic idx_pulse();
    @(posedge clk); #1;
    idx = 1'b1;
    settle(4);
    idx = 1'b0;
    settle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    chk("R12 count", 32'(count), 0);
    chk("R12 dir", 32'(dir), 1);
    chk("R12 perr", 32'(perr), 0);
    chk("R12 sts", 32'(sts), 0);
    chk("R12 irq", 32'(irq), 0);

    cfg(1'b0, 1'b0, 3'b111, 2'd0, 1'b1, 8'd5, 4'd0);
    cfg(1'b1, 1'b0, 3'b111, 2'd0, 1'b1, 8'd5, 4'd0);

    for (int i = 0; i < NVEC; i++) begin
      pins(VEC[i][10], VEC[i][9]);
      chk($sformatf("R1/R2 count vec %0d", i), 32'(count), 32'(VEC[i][8:1]));
      chk($sformatf("R1 R2 dir vec %0d", i), 32'(dir), 32'(VEC[i][0]));
    end
    // R6 both wraps and R2 direction change seen, all masked
    chk("R6 status after wraps", 32'(sts), 32'h0e);
    chk("R11 masked irq", 32'(irq), 0);

    // R5 both phases change: 00 -> 11
    pins(1'b1, 1'b1);
    chk("R5 count held", 32'(count), 4);
    chk("R5 perr set", 32'(perr), 1);
    settle(3);
    chk("R5 perr sticky", 32'(perr), 1);
    @(posedge clk); #1; perr_clr = 1'b1;
    @(posedge clk); #1; perr_clr = 1'b0;
    settle(1);
    chk("R5 perr cleared", 32'(perr), 0);

    // R9 freeze while disabled
    cfg(1'b0, 1'b0, 3'b111, 2'd0, 1'b1, 8'd5, 4'd0);
    pins(1'b0, 1'b1);
    chk("R9 frozen", 32'(count), 4);
    cfg(1'b1, 1'b0, 3'b111, 2'd0, 1'b1, 8'd5, 4'd0);
    chk("R9 resume held", 32'(count), 4);
    pins(1'b0, 1'b0);
    chk("R9 resume count", 32'(count), 5);

    // R8 ceiling write while enabled ignored
    cfg(1'b1, 1'b0, 3'b111, 2'd0, 1'b1, 8'd2, 4'd0);
    pins(1'b1, 1'b0);
    chk("R8 old ceiling wrap", 32'(count), 0);

    // R11 status, mask, clear
    chk("R11 status", 32'(sts), 32'h0e);
    @(posedge clk); #1; msk = 4'b1011; msk_wr = 1'b1;
    @(posedge clk); #1; msk_wr = 1'b0;
    settle(1);
    chk("R11 irq unmasked", 32'(irq), 1);
    clear_sts(4'b0100);
    chk("R11 w1c one bit", 32'(sts), 32'h0a);
    chk("R11 irq after clear", 32'(irq), 0);
    clear_sts(4'b1111);
    chk("R11 all cleared", 32'(sts), 0);

    // R3 swap: pins 10 -> 11 counts down
    cfg(1'b0, 1'b0, 3'b111, 2'd0, 1'b1, 8'd5, 4'd0);
    cfg(1'b0, 1'b1, 3'b111, 2'd0, 1'b1, 8'd5, 4'd0);
    cfg(1'b1, 1'b1, 3'b111, 2'd0, 1'b1, 8'd5, 4'd0);
    pins(1'b1, 1'b1);
    chk("R3 swapped down wrap", 32'(count), 5);
    chk("R3 swapped dir", 32'(dir), 0);

    // R4 invert A: pins 11 -> 01 counts down
    cfg(1'b0, 1'b1, 3'b111, 2'd0, 1'b1, 8'd5, 4'd0);
    cfg(1'b0, 1'b0, 3'b110, 2'd0, 1'b1, 8'd5, 4'd0);
    cfg(1'b1, 1'b0, 3'b110, 2'd0, 1'b1, 8'd5, 4'd0);
    pins(1'b0, 1'b1);
    chk("R4 inverted A", 32'(count), 4);
    chk("R4 inverted dir", 32'(dir), 0);

    // R7 index mode, gate 3
    cfg(1'b0, 1'b0, 3'b110, 2'd0, 1'b1, 8'd5, 4'd0);
    cfg(1'b0, 1'b0, 3'b111, 2'd3, 1'b0, 8'd5, 4'd0);
    pins(1'b1, 1'b1);
    cfg(1'b1, 1'b0, 3'b111, 2'd3, 1'b0, 8'd5, 4'd0);
    chk("R7 before index", 32'(count), 4);
    idx_pulse();
    chk("R7 gated index reset", 32'(count), 0);
    pins(1'b0, 1'b1);
    chk("R7 step after index", 32'(count), 1);
    cfg(1'b0, 1'b0, 3'b111, 2'd3, 1'b0, 8'd5, 4'd0);
    cfg(1'b0, 1'b0, 3'b111, 2'd0, 1'b0, 8'd5, 4'd0);
    cfg(1'b1, 1'b0, 3'b111, 2'd0, 1'b0, 8'd5, 4'd0);
    idx_pulse();
    chk("R7 index off gate ignored", 32'(count), 1);
    pins(1'b0, 1'b0);
    pins(1'b1, 1'b0);
    pins(1'b1, 1'b1);
    pins(1'b0, 1'b1);
    pins(1'b0, 1'b0);
    chk("R7 no ceiling wrap", 32'(count), 6);
    idx_pulse();
    chk("R7 index at gate 0", 32'(count), 0);

    // R10 watchdog
    clear_sts(4'b1111);
    chk("R10 off when limit 0", 32'(sts[0]), 0);
    cfg(1'b0, 1'b0, 3'b111, 2'd0, 1'b1, 8'd5, 4'd0);
    cfg(1'b0, 1'b0, 3'b111, 2'd0, 1'b1, 8'd5, 4'd6);
    cfg(1'b1, 1'b0, 3'b111, 2'd0, 1'b1, 8'd5, 4'd6);
    settle(10);
    chk("R10 timeout status", 32'(sts[0]), 1);
    chk("R10 count untouched", 32'(count), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule